// File: doc/BRIEF.md
# Indirect Pointer Load Unit

This block keeps two 16-bit address pointers and carries out "load indirect into the working register" operations. Each request names one of the two pointers and how to form the address. The address is either the pointer stepped by one before the access, the pointer itself with a step by one after the access, or the pointer plus a small signed displacement that leaves the pointer as it is. The block issues one read on a synchronous memory port and loads the returned byte into an 8-bit working register. It sets a zero flag from that byte and writes the updated pointer back.

Memory data comes back one cycle after the read strobe. The working register, the zero flag and the pointer writeback all take effect at the end of that return cycle, and `done` is high during it. While an operation is pending, `busy` is high and new requests are dropped. Software-style pointer loads go through a separate write port, which always wins over a pending writeback to the same pointer.

Top module: `ptr_load_unit`

## Requirements
- R1: On synchronous reset (`rst` high at a clock edge), both pointers, `wreg`, `zflag`, `busy` and `done` become zero.
- R2: With `op_rel`=0 and `op_step`=2'b00 (step up before access), `mem_addr` is pointer+1 and the pointer becomes pointer+1.
- R3: With `op_rel`=0 and `op_step`=2'b01 (step down before access), `mem_addr` is pointer-1 and the pointer becomes pointer-1.
- R4: With `op_rel`=0 and `op_step`=2'b10 or 2'b11 (access then step up or down), `mem_addr` is the current pointer, and the pointer then becomes pointer+1 (2'b10) or pointer-1 (2'b11).
- R5: With `op_rel`=1, `mem_addr` is the pointer plus `op_off`, a 6-bit two's-complement value (-32..+31). The pointer is unchanged and `op_step` has no effect.
- R6: All pointer and address arithmetic wraps modulo 2^16 (FFFFh+1 = 0000h, 0000h-1 = FFFFh).
- R7: An accepted request (`op_req` high while `busy` low) raises `mem_rd` in that same cycle. In the next cycle `done` and `busy` are high. At the end of that cycle, `wreg` takes `mem_rdata` and `zflag` becomes 1 exactly when that byte is zero, and the pointer writeback happens at the same edge.
- R8: A request made while `busy` is high is ignored. It causes no `mem_rd` and changes no pointer or `wreg`.
- R9: `ptr_we` loads `ptr_wdata` into the pointer named by `ptr_wsel` at the next edge. If that pointer is the one of an operation being accepted or pending, the direct write wins and the operation's pointer writeback is dropped.
- R10: An operation on one pointer never changes the other pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_req | input | 1 | Operation request |
| op_sel | input | 1 | Pointer index for the operation |
| op_rel | input | 1 | 1 selects displacement addressing |
| op_step | input | 2 | Step mode: 00 pre-up, 01 pre-down, 10 post-up, 11 post-down |
| op_off | input | 6 | Signed displacement for displacement addressing |
| ptr_we | input | 1 | Direct pointer write enable |
| ptr_wsel | input | 1 | Pointer index for the direct write |
| ptr_wdata | input | 16 | Direct pointer write value |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after `mem_rd` |
| wreg | output | 8 | Working register |
| zflag | output | 1 | Zero flag |
| busy | output | 1 | Operation pending |
| done | output | 1 | Result commits at the end of this cycle |
| ptr0 | output | 16 | Pointer 0 value |
| ptr1 | output | 16 | Pointer 1 value |

## Verification
The assertions assume that the memory answers every strobe with a byte on `mem_rdata` in the following cycle, and that the operation fields stay at their known values while `op_req` is high. The bench models a memory that registers a byte derived from the strobed address, so the expected data for every address is known. It drives all inputs at the falling edge and holds them steady through the rising edge. Direct writes and requests are deliberately overlapped only in the accept and pending cycles, where the priority rule defines the outcome.

// File: rtl/ptr_load_unit.sv
module ptr_load_unit #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_req,
  input  logic          op_sel,
  input  logic          op_rel,
  input  logic [1:0]    op_step,
  input  logic [OW-1:0] op_off,
  input  logic          ptr_we,
  input  logic          ptr_wsel,
  input  logic [AW-1:0] ptr_wdata,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] wreg,
  output logic          zflag,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ptr0,
  output logic [AW-1:0] ptr1
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] ptr_q [2];
  logic          pend_q, psel_q, kill_q;
  logic [AW-1:0] pnxt_q;
  logic [AW-1:0] cur, ea, nxt, off_x;

  wire accept = op_req && !pend_q;

  assign cur   = op_sel ? ptr_q[1] : ptr_q[0];
  assign off_x = {{(AW-OW){op_off[OW-1]}}, op_off};

  always_comb begin
    ea  = cur;
    nxt = cur;
    if (op_rel) begin
      ea = cur + off_x;
    end else begin
      case (op_step)
        2'b00: begin ea = cur + ONE; nxt = cur + ONE; end
        2'b01: begin ea = cur - ONE; nxt = cur - ONE; end
        2'b10: nxt = cur + ONE;
        default: nxt = cur - ONE;
      endcase
    end
  end

  assign mem_rd   = accept;
  assign mem_addr = ea;
  assign busy     = pend_q;
  assign done     = pend_q;
  assign ptr0     = ptr_q[0];
  assign ptr1     = ptr_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      psel_q <= 1'b0;
      kill_q <= 1'b0;
      pnxt_q <= '0;
      wreg   <= '0;
      zflag  <= 1'b0;
      ptr_q[0] <= '0;
      ptr_q[1] <= '0;
    end else begin
      pend_q <= accept;
      if (accept) begin
        psel_q <= op_sel;
        pnxt_q <= nxt;
        kill_q <= ptr_we && (ptr_wsel == op_sel);
      end
      if (pend_q) begin
        wreg  <= mem_rdata;
        zflag <= (mem_rdata == '0);
      end
      for (int i = 0; i < 2; i++) begin
        if (ptr_we && (ptr_wsel == i[0]))
          ptr_q[i] <= ptr_wdata;
        else if (pend_q && (psel_q == i[0]) && !kill_q)
          ptr_q[i] <= pnxt_q;
      end
    end
  end
endmodule

module ptr_load_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int OW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          op_req,
  input logic          op_sel,
  input logic          op_rel,
  input logic [1:0]    op_step,
  input logic [OW-1:0] op_off,
  input logic          ptr_we,
  input logic          ptr_wsel,
  input logic [AW-1:0] ptr_wdata,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] wreg,
  input logic          zflag,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] ptr0,
  input logic [AW-1:0] ptr1
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ptr0 == '0 && ptr1 == '0 && wreg == '0 && !zflag && !busy && !done));

  a_r7_done_follows_read: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> (done && busy));

  a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    done |=> (zflag == (wreg == '0)));

  a_r7_wreg_loaded: assert property (@(posedge clk) disable iff (rst)
    done |=> (wreg == $past(mem_rdata)));

  a_r8_no_read_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !mem_rd);

  a_r7_wreg_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(wreg));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    (ptr_we && !ptr_wsel) |=> (ptr0 == $past(ptr_wdata)));

  a_r10_ptr1_quiet: assert property (@(posedge clk) disable iff (rst)
    (!done && !(ptr_we && ptr_wsel)) |=> $stable(ptr1));
endmodule

bind ptr_load_unit ptr_load_unit_chk #(.AW(AW), .DW(DW), .OW(OW)) u_chk (.*);

// File: tb/ptr_load_unit_tb.sv
module ptr_load_unit_tb;
  logic clk = 1'b0;
  logic rst, op_req, op_sel, op_rel, ptr_we, ptr_wsel;
  logic [1:0] op_step;
  logic [5:0] op_off;
  logic [15:0] ptr_wdata, mem_addr, ptr0, ptr1;
  logic [7:0] mem_rdata, wreg;
  logic mem_rd, zflag, busy, done;

  int checks = 0;
  int errors = 0;
  logic [15:0] mp [2];

  always #4 clk = ~clk;

  ptr_load_unit u_dut (.*);

  function automatic logic [7:0] mdata(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mdata(mem_addr);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    op_req = 0; op_sel = 0; op_rel = 0; op_step = 0; op_off = 0;
    ptr_we = 0; ptr_wsel = 0; ptr_wdata = 0;
  endtask

  task automatic wr_ptr(input logic s, input logic [15:0] v);
    @(negedge clk);
    ptr_we = 1; ptr_wsel = s; ptr_wdata = v;
    @(negedge clk);
    ptr_we = 0;
    mp[s] = v;
    chk((s ? ptr1 : ptr0) == v, "R9 direct write", s ? ptr1 : ptr0, v);
  endtask

  task automatic run_op(input logic s, input logic rel, input logic [1:0] st,
                        input logic [5:0] off, input string tag);
    logic [15:0] cur, ea, nxt;
    cur = mp[s];
    if (rel) begin ea = cur + {{10{off[5]}}, off}; nxt = cur; end
    else case (st)
      2'b00: begin ea = cur + 1; nxt = ea; end
      2'b01: begin ea = cur - 1; nxt = ea; end
      2'b10: begin ea = cur; nxt = cur + 1; end
      default: begin ea = cur; nxt = cur - 1; end
    endcase
    @(negedge clk);
    op_req = 1; op_sel = s; op_rel = rel; op_step = st; op_off = off;
    #1;
    chk(mem_rd == 1, {tag, " R7 strobe"}, mem_rd, 1);
    chk(mem_addr == ea, {tag, " address"}, mem_addr, ea);
    @(negedge clk);
    op_req = 0;
    chk(done && busy, {tag, " R7 done"}, {done, busy}, 2'b11);
    @(negedge clk);
    mp[s] = nxt;
    chk(wreg == mdata(ea), {tag, " R7 wreg"}, wreg, mdata(ea));
    chk(zflag == (mdata(ea) == 0), {tag, " R7 zflag"}, zflag, mdata(ea) == 0);
    chk(ptr0 == mp[0] && ptr1 == mp[1], {tag, " R10 pointers"}, {ptr1, ptr0}, {mp[1], mp[0]});
    chk(!done, {tag, " R7 done drop"}, done, 0);
  endtask

  task automatic t_reset();
    idle();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    mp[0] = 0; mp[1] = 0;
    chk(ptr0 == 0 && ptr1 == 0, "R1 pointers", {ptr1, ptr0}, 0);
    chk(wreg == 0 && !zflag && !busy && !done, "R1 state", {wreg, zflag, busy, done}, 0);
  endtask

  task automatic t_modes();
    wr_ptr(0, 16'h1234);
    wr_ptr(1, 16'h0300);
    run_op(0, 0, 2'b00, 0, "R2 pre-up");
    run_op(0, 0, 2'b01, 0, "R3 pre-down");
    run_op(1, 0, 2'b10, 0, "R4 post-up");
    run_op(1, 0, 2'b11, 0, "R4 post-down");
    run_op(0, 1, 2'b00, 6'd31, "R5 rel +31");
    run_op(0, 1, 2'b10, 6'b100000, "R5 rel -32");
    run_op(1, 1, 2'b11, 6'b111111, "R5 rel -1");
  endtask

  task automatic t_wrap();
    wr_ptr(0, 16'hFFFF);
    run_op(0, 0, 2'b00, 0, "R6 up wrap zero");
    wr_ptr(1, 16'h0000);
    run_op(1, 0, 2'b11, 0, "R6 down wrap");
    run_op(1, 0, 2'b10, 0, "R6 up from FFFF");
    wr_ptr(0, 16'h0010);
    run_op(0, 1, 2'b00, 6'b100000, "R6 rel wrap");
    wr_ptr(0, 16'h1212);
    run_op(0, 0, 2'b10, 0, "R7 zero byte");
  endtask

  task automatic t_busy();
    wr_ptr(0, 16'h0040);
    @(negedge clk);
    op_req = 1; op_sel = 0; op_rel = 0; op_step = 2'b10;
    @(negedge clk);
    op_sel = 1; op_step = 2'b00;
    #1;
    chk(mem_rd == 0, "R8 no strobe when busy", mem_rd, 0);
    @(negedge clk);
    op_req = 0;
    chk(ptr0 == 16'h0041 && ptr1 == mp[1], "R8 ignored request", {ptr1, ptr0}, {mp[1], 16'h0041});
    chk(wreg == mdata(16'h0040), "R8 wreg from first op", wreg, mdata(16'h0040));
    mp[0] = 16'h0041;
    @(negedge clk);
    chk(ptr1 == mp[1] && !busy, "R8 nothing started", {busy, ptr1}, {1'b0, mp[1]});
  endtask

  task automatic t_priority();
    wr_ptr(0, 16'h0100);
    @(negedge clk);
    op_req = 1; op_sel = 0; op_rel = 0; op_step = 2'b00;
    @(negedge clk);
    op_req = 0; ptr_we = 1; ptr_wsel = 0; ptr_wdata = 16'hABCD;
    @(negedge clk);
    ptr_we = 0;
    chk(ptr0 == 16'hABCD, "R9 write over pending", ptr0, 16'hABCD);
    chk(wreg == mdata(16'h0101), "R9 load still done", wreg, mdata(16'h0101));
    @(negedge clk);
    op_req = 1; op_sel = 1; op_step = 2'b10; ptr_we = 1; ptr_wsel = 1; ptr_wdata = 16'h5555;
    @(negedge clk);
    op_req = 0; ptr_we = 0;
    @(negedge clk);
    chk(ptr1 == 16'h5555, "R9 write in accept cycle", ptr1, 16'h5555);
    mp[0] = 16'hABCD; mp[1] = 16'h5555;
    @(negedge clk);
    op_req = 1; op_sel = 0; op_step = 2'b01;
    @(negedge clk);
    op_req = 0; ptr_we = 1; ptr_wsel = 1; ptr_wdata = 16'h7777;
    @(negedge clk);
    ptr_we = 0;
    chk(ptr0 == 16'hABCC && ptr1 == 16'h7777, "R10 other pointer write",
        {ptr1, ptr0}, {16'h7777, 16'hABCC});
    mp[0] = 16'hABCC; mp[1] = 16'h7777;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_wrap();
    t_busy();
    t_priority();
    run_op(1, 0, 2'b00, 0, "R2 after priority");
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule